// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block stores incoming frames into a circular buffer built from 256-byte pages. The host programs the first page of the ring and the page just past its end, and it owns a boundary page that marks data not yet consumed. The block owns the current page, which is where the next frame goes. A frame arrives as a start marker, a run of data bytes and an end marker that carries the frame's status flags. The block writes the data bytes through a byte-wide memory port, starting four bytes into the current page. After the frame ends, it goes back and fills those four leading bytes with a header. The header holds a status byte, the page where the following frame will start, and a 16-bit length.

The block never writes into the boundary page. A frame that would need it is abandoned: no header is written, the current page does not move, and the block reports an overwrite and a missed frame. In monitor mode, frames are only classified. Nothing is written and every frame is reported as missed. The current page is reloaded from the ring's first page during the synchronous reset. The boundary page and the ring limits must be held steady while a frame is in progress.

Top module: `rx_page_ring`

## Requirements
- R1: During and right after the synchronous reset (rst_n low), cur_page equals page_start, mem_we is low, and ev_rx_ok, ev_overwrite and ev_missed are low.
- R2: Data bytes (rx_valid high between rx_sof and rx_eof, with rx_eof on a cycle of its own) are written in arrival order. The first one goes to byte offset 4 of the current page, where mem_addr = {page, offset}. Each write appears on the memory port one cycle after its byte is accepted.
- R3: After offset 255, writing continues at offset 0 of the next page. The page after page_stop-1 is page_start.
- R4: After rx_eof, four consecutive header writes go to offsets 0,1,2,3 of the frame's first page: the status byte, the next-frame page, the count low byte, and the count high byte. The count is the number of data bytes plus 4.
- R5: The next-frame page is the page after the last page that holds frame data. A frame that ends exactly at offset 255 does not claim an extra page. cur_page takes this value in the cycle after the last header write.
- R6: Status byte bits are: 0 stored with no error, 1 CRC error, 2 alignment error, 3 FIFO overrun, 4 missed, 5 group (multicast/broadcast) address, 6 monitor mode, 7 deferring. The status byte is shown on last_status from the cycle after rx_eof.
- R7: An alignment error also sets status bit 1.
- R8: A frame that starts on the boundary page, or that needs a byte written into it, stops writing at that point. It gets no header and cur_page stays unchanged. ev_overwrite and ev_missed pulse for one cycle right after rx_eof, and status bit 4 is set.
- R9: With monitor_en high at rx_sof, the frame causes no memory write. ev_missed pulses after rx_eof, ev_overwrite stays low, and status bits 4 and 6 are set.
- R10: ev_rx_ok pulses for one cycle, together with the cur_page update, only for a stored frame with no CRC, alignment or FIFO error. Stored frames that have errors keep their data and header, but they do not pulse ev_rx_ok.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| page_start | input | PAGE_W | First page of the ring |
| page_stop | input | PAGE_W | Page just past the ring |
| bnd_page | input | PAGE_W | Host boundary page, never written |
| monitor_en | input | 1 | Classify frames without storing them |
| rx_sof | input | 1 | Frame start marker |
| rx_valid | input | 1 | Data byte valid |
| rx_data | input | 8 | Data byte |
| rx_eof | input | 1 | Frame end marker, qualifies the status flags |
| rx_crc_err | input | 1 | CRC error flag |
| rx_align_err | input | 1 | Alignment error flag |
| rx_fifo_err | input | 1 | FIFO overrun flag |
| rx_group | input | 1 | Group address match flag |
| rx_defer | input | 1 | Deferring flag |
| mem_we | output | 1 | Buffer write strobe |
| mem_addr | output | PAGE_W+8 | Buffer byte address |
| mem_wdata | output | 8 | Buffer write data |
| cur_page | output | PAGE_W | Page where the next frame starts |
| last_status | output | 8 | Status byte of the latest frame |
| ev_rx_ok | output | 1 | Good frame stored pulse |
| ev_overwrite | output | 1 | Boundary reached pulse |
| ev_missed | output | 1 | Frame not stored pulse |

## Verification
The bench builds the block with PAGE_W = 8 and drives a ring of only four pages, 0x40 to 0x43. With a ring that small, a 300-byte frame wraps from the last page to the first, a frame of exactly 252 bytes fills one page to its final offset, and moving the boundary page one step lets the block reach it both at frame start and in the middle of a frame. Each case is checked against addresses and header bytes that the bench computes from the page arithmetic.

// File: rtl/rx_page_ring.sv
module rx_page_ring #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] page_start,
  input  logic [PAGE_W-1:0] page_stop,
  input  logic [PAGE_W-1:0] bnd_page,
  input  logic              monitor_en,
  input  logic              rx_sof,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_eof,
  input  logic              rx_crc_err,
  input  logic              rx_align_err,
  input  logic              rx_fifo_err,
  input  logic              rx_group,
  input  logic              rx_defer,
  output logic              mem_we,
  output logic [PAGE_W+7:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [PAGE_W-1:0] cur_page,
  output logic [7:0]        last_status,
  output logic              ev_rx_ok,
  output logic              ev_overwrite,
  output logic              ev_missed
);
  localparam int ADDR_W = PAGE_W + 8;
  localparam int CNT_W  = 16;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_HDR} state_t;

  state_t            st;
  logic [PAGE_W-1:0] start_pg, wr_pg, next_pg;
  logic [7:0]        wr_off;
  logic [CNT_W-1:0]  byte_cnt, cnt_r;
  logic [1:0]        hdr_idx;
  logic              drop_mon, drop_ovf;

  function automatic logic [PAGE_W-1:0] step_page(input logic [PAGE_W-1:0] p,
                                                   input logic [PAGE_W-1:0] lo,
                                                   input logic [PAGE_W-1:0] hi);
    logic [PAGE_W-1:0] q;
    q = p + 1'b1;
    return (q == hi) ? lo : q;
  endfunction

  wire [PAGE_W-1:0] pg_after = step_page(wr_pg, page_start, page_stop);
  wire              missed   = drop_mon | drop_ovf;
  wire              has_err  = rx_crc_err | rx_align_err | rx_fifo_err;
  wire [7:0]        fr_status = {rx_defer, drop_mon, rx_group, missed, rx_fifo_err,
                                 rx_align_err, rx_crc_err | rx_align_err, ~(has_err | missed)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cur_page     <= page_start;
      start_pg     <= '0;
      wr_pg        <= '0;
      next_pg      <= '0;
      wr_off       <= '0;
      byte_cnt     <= '0;
      cnt_r        <= '0;
      hdr_idx      <= '0;
      drop_mon     <= 1'b0;
      drop_ovf     <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      last_status  <= '0;
      ev_rx_ok     <= 1'b0;
      ev_overwrite <= 1'b0;
      ev_missed    <= 1'b0;
    end else begin
      mem_we       <= 1'b0;
      ev_rx_ok     <= 1'b0;
      ev_overwrite <= 1'b0;
      ev_missed    <= 1'b0;
      case (st)
        S_IDLE: begin
          if (rx_sof) begin
            st       <= S_DATA;
            start_pg <= cur_page;
            wr_pg    <= cur_page;
            wr_off   <= 8'd4;
            byte_cnt <= '0;
            drop_mon <= monitor_en;
            drop_ovf <= !monitor_en && (cur_page == bnd_page);
          end
        end
        S_DATA: begin
          if (rx_eof) begin
            last_status <= fr_status;
            if (missed) begin
              ev_missed    <= 1'b1;
              ev_overwrite <= drop_ovf;
              st           <= S_IDLE;
            end else begin
              st      <= S_HDR;
              hdr_idx <= 2'd0;
              next_pg <= (wr_off == 8'd0) ? wr_pg : pg_after;
              cnt_r   <= byte_cnt + CNT_W'(4);
            end
          end else if (rx_valid) begin
            byte_cnt <= byte_cnt + 1'b1;
            if (!missed) begin
              if (wr_pg == bnd_page) begin
                drop_ovf <= 1'b1;
              end else begin
                mem_we    <= 1'b1;
                mem_addr  <= {wr_pg, wr_off};
                mem_wdata <= rx_data;
                wr_off    <= wr_off + 1'b1;
                if (wr_off == 8'hFF) wr_pg <= pg_after;
              end
            end
          end
        end
        S_HDR: begin
          mem_we   <= 1'b1;
          mem_addr <= {start_pg, 6'd0, hdr_idx};
          case (hdr_idx)
            2'd0:    mem_wdata <= last_status;
            2'd1:    mem_wdata <= 8'(next_pg);
            2'd2:    mem_wdata <= cnt_r[7:0];
            default: mem_wdata <= cnt_r[15:8];
          endcase
          hdr_idx <= hdr_idx + 1'b1;
          if (hdr_idx == 2'd3) begin
            st       <= S_IDLE;
            cur_page <= next_pg;
            ev_rx_ok <= last_status[0];
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_in_ring_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[ADDR_W-1:8] >= page_start && mem_addr[ADDR_W-1:8] < page_stop));

  assert_skip_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[ADDR_W-1:8] != bnd_page);

  assert_overwrite_missed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overwrite |-> (ev_missed && last_status[4]));

  assert_missed_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_missed |-> !mem_we && !ev_rx_ok);

  assert_ok_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_ok |-> (last_status[3:0] == 4'b0001) && !last_status[4]);

  assert_align_crc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_status[2] |-> last_status[1]);

  assert_page_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_page != $past(cur_page)) |-> ev_rx_ok || !last_status[4]);
endmodule

// File: tb/rx_page_ring_test.sv
module rx_page_ring_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] page_start = 8'h40, page_stop = 8'h44, bnd_page = 8'h43;
  logic monitor_en = 1'b0;
  logic rx_sof = 1'b0, rx_valid = 1'b0, rx_eof = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_crc_err = 1'b0, rx_align_err = 1'b0, rx_fifo_err = 1'b0, rx_group = 1'b0, rx_defer = 1'b0;
  logic mem_we;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, cur_page, last_status;
  logic ev_rx_ok, ev_overwrite, ev_missed;

  rx_page_ring #(.PAGE_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .page_start(page_start), .page_stop(page_stop),
    .bnd_page(bnd_page), .monitor_en(monitor_en), .rx_sof(rx_sof), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_eof(rx_eof), .rx_crc_err(rx_crc_err), .rx_align_err(rx_align_err),
    .rx_fifo_err(rx_fifo_err), .rx_group(rx_group), .rx_defer(rx_defer), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cur_page(cur_page), .last_status(last_status),
    .ev_rx_ok(ev_rx_ok), .ev_overwrite(ev_overwrite), .ev_missed(ev_missed));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] la [0:1023];
  logic [7:0]  ld [0:1023];
  int n_wr = 0, n_ok = 0, n_ovw = 0, n_miss = 0;

  always @(negedge clk) if (rst_n) begin
    if (mem_we && n_wr < 1024) begin la[n_wr] = mem_addr; ld[n_wr] = mem_wdata; end
    if (mem_we) n_wr++;
    if (ev_rx_ok) n_ok++;
    if (ev_overwrite) n_ovw++;
    if (ev_missed) n_miss++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bnext(input logic [7:0] p);
    return (p + 8'd1 == page_stop) ? page_start : p + 8'd1;
  endfunction

  function automatic logic [15:0] exp_addr(input logic [7:0] p0, input int idx);
    int pos = idx + 4;
    logic [7:0] p = p0;
    while (pos >= 256) begin p = bnext(p); pos -= 256; end
    return {p, 8'(pos)};
  endfunction

  task automatic send_frame(input int n, input logic [7:0] seed, input logic [4:0] fl);
    n_wr = 0; n_ok = 0; n_ovw = 0; n_miss = 0;
    @(negedge clk) rx_sof = 1'b1;
    @(negedge clk) rx_sof = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = seed + 8'(i);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    {rx_defer, rx_group, rx_fifo_err, rx_align_err, rx_crc_err} = fl;
    rx_eof = 1'b1;
    @(negedge clk);
    rx_eof = 1'b0;
    {rx_defer, rx_group, rx_fifo_err, rx_align_err, rx_crc_err} = 5'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic check_stored(input string tag, input int n, input logic [7:0] seed,
                              input logic [7:0] p0, input logic [7:0] st, input logic [7:0] nxt);
    int bad = -1;
    int cnt = n + 4;
    check(n_wr == n + 4, {tag, " R2 write count"}, n_wr, n + 4);
    for (int i = 0; i < n; i++)
      if (bad < 0 && (la[i] != exp_addr(p0, i) || ld[i] != seed + 8'(i))) bad = i;
    check(bad < 0, {tag, " R2 R3 data address/value"}, bad < 0 ? 0 : int'(la[bad]),
          bad < 0 ? 0 : int'(exp_addr(p0, bad)));
    for (int k = 0; k < 4; k++)
      check(la[n + k] == {p0, 8'(k)}, {tag, " R4 header address"}, la[n + k], {p0, 8'(k)});
    check(ld[n] == st, {tag, " R6 header status"}, ld[n], st);
    check(ld[n + 1] == nxt, {tag, " R5 header next page"}, ld[n + 1], nxt);
    check({ld[n + 3], ld[n + 2]} == 16'(cnt), {tag, " R4 header count"}, {ld[n + 3], ld[n + 2]}, cnt);
    check(cur_page == nxt, {tag, " R5 cur_page"}, cur_page, nxt);
    check(last_status == st, {tag, " R6 last_status"}, last_status, st);
    check(n_ok == (st[0] ? 1 : 0), {tag, " R10 ok pulse"}, n_ok, st[0]);
    check(n_miss == 0 && n_ovw == 0, {tag, " R8 no drop events"}, n_miss + n_ovw, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(cur_page == 8'h40, "R1 cur_page in reset", cur_page, 8'h40);
    check(!mem_we && !ev_rx_ok && !ev_overwrite && !ev_missed, "R1 outputs idle in reset",
          {mem_we, ev_rx_ok, ev_overwrite, ev_missed}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cur_page == 8'h40 && !mem_we, "R1 after release", cur_page, 8'h40);
  endtask

  task automatic t_basic;
    send_frame(10, 8'h10, 5'b0);
    check_stored("basic", 10, 8'h10, 8'h40, 8'h01, 8'h41);
  endtask

  task automatic t_crc_group;
    send_frame(6, 8'h30, 5'b01001);
    check_stored("crc+group", 6, 8'h30, 8'h41, 8'h22, 8'h42);
  endtask

  task automatic t_align;
    send_frame(5, 8'h50, 5'b00010);
    check_stored("align R7", 5, 8'h50, 8'h42, 8'h06, 8'h43);
  endtask

  task automatic t_start_on_boundary;
    send_frame(3, 8'h60, 5'b0);
    check(n_wr == 0, "R8 no write on boundary start", n_wr, 0);
    check(n_ovw == 1 && n_miss == 1, "R8 overwrite+missed pulses", {n_ovw, n_miss}, 2'b11);
    check(last_status == 8'h10, "R8 status", last_status, 8'h10);
    check(cur_page == 8'h43 && n_ok == 0, "R8 cur_page kept", cur_page, 8'h43);
  endtask

  task automatic t_wrap;
    bnd_page = 8'h41;
    send_frame(300, 8'h80, 5'b0);
    check_stored("wrap R3", 300, 8'h80, 8'h43, 8'h01, 8'h41);
    check(la[252] == 16'h4000, "R3 wrap to page_start", la[252], 16'h4000);
  endtask

  task automatic t_exact_fill;
    bnd_page = 8'h40;
    send_frame(252, 8'h07, 5'b0);
    check_stored("exact R5", 252, 8'h07, 8'h41, 8'h01, 8'h42);
  endtask

  task automatic t_mid_overflow;
    bnd_page = 8'h43;
    send_frame(300, 8'h11, 5'b0);
    check(n_wr == 252, "R8 writes stop before boundary", n_wr, 252);
    check(n_ovw == 1 && n_miss == 1 && n_ok == 0, "R8 mid-frame events", {n_ok, n_ovw, n_miss}, 3'b011);
    check(last_status == 8'h10, "R8 mid-frame status", last_status, 8'h10);
    check(cur_page == 8'h42, "R8 cur_page kept mid-frame", cur_page, 8'h42);
  endtask

  task automatic t_monitor;
    monitor_en = 1'b1;
    send_frame(20, 8'h22, 5'b10000);
    monitor_en = 1'b0;
    check(n_wr == 0, "R9 monitor no writes", n_wr, 0);
    check(n_miss == 1 && n_ovw == 0, "R9 missed only", {n_ovw, n_miss}, 2'b01);
    check(last_status == 8'hD0, "R9 monitor status", last_status, 8'hD0);
    check(cur_page == 8'h42, "R9 cur_page kept", cur_page, 8'h42);
  endtask

  task automatic t_fifo;
    bnd_page = 8'h40;
    send_frame(4, 8'hA0, 5'b00100);
    check_stored("fifo R10", 4, 8'hA0, 8'h42, 8'h08, 8'h43);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_crc_group();
    t_align();
    t_start_on_boundary();
    t_wrap();
    t_exact_fill();
    t_mid_overflow();
    t_monitor();
    t_fifo();
    done = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
    end
  end
endmodule